// File: doc/BRIEF.md
# Eight-Bit ALU with Selective Status Flags

This block is the arithmetic and logic stage of a small register-to-register microcontroller core. Each instruction brings two 8-bit operands, which come from registers or an immediate field, the current carry flag and the current zero flag. The block returns an 8-bit result, a six-bit flag vector and a write mask over that vector. The mask marks the flags that the selected operation updates. The surrounding core merges the flags under the mask into its status register. It writes the result back only when the block asks for it.

The block is purely combinational. Its outputs follow its inputs within the same cycle, so the core's writeback registers sample them at the next edge. There is no stream of data to hold back, so the block has no valid/ready handshake: one operation is presented per cycle and it always completes.

The subtract-with-carry and compare-with-carry operations can only clear the zero flag. They never set it, so Z stays valid across a chain of byte-wise operations on a multi-byte value.

Top module: `alu8`

## Requirements
- R1: `flags_o` and `flags_we_o` use bit 0 = C, 1 = Z, 2 = N, 3 = V, 4 = S, 5 = H. Z is set when the result is zero, N is result bit 7, and S = N xor V. S is written whenever N is written. A flag bit that is not written reads 0.
- R2: ADD (op 0) and ADC (op 1, which also adds `carry_i`) produce the 8-bit sum. C is the carry out of bit 7, H is the carry out of bit 3, and V is two's-complement overflow. The mask covers C, Z, N, V, S and H.
- R3: SUB (op 2) and SBC (op 3, which also subtracts `carry_i`) produce the difference. C is set on an unsigned borrow and H on a borrow out of bit 3. V is signed overflow. The mask covers all six flags.
- R4: CP (op 4) and CPC (op 5) set the flags exactly as SUB and SBC do, with `res_wr_o` low. For SBC and CPC, Z is 1 only when the result is zero and `zero_i` is 1. Every other defined op drives `res_wr_o` high.
- R5: NEG (op 6) gives 0x00 minus A. C is set when A is non-zero, H on a borrow out of bit 3, and V when A is 0x80. All six flags are written. COM (op 7) gives 0xFF minus A with C = 1 and V = 0. It writes C, Z, N, V and S, not H.
- R6: AND (op 8), OR (op 9), XOR (op 10), SBR (op 11, A or B) and CBR (op 12, A and not B) write only Z, N, V and S, with V = 0.
- R7: INC (op 13) gives A+1 and DEC (op 14) gives A-1. Both write only Z, N, V and S. V is set by INC only for A = 0x7F and by DEC only for A = 0x80.
- R8: LSL (op 15) shifts left and fills bit 0 with 0, with C = old bit 7. LSR (op 16) shifts right and fills bit 7 with 0, with C = old bit 0. ROL (op 17) shifts left and puts `carry_i` into bit 0, with C = old bit 7. All three write C, Z, N, V and S, with V = N xor C.
- R9: Op codes 18 to 31 give result 0, flags 0, mask 0 and `res_wr_o` low.
- R10: The outputs are a combinational function of the present inputs, and hold no state between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation select (codes in R2 to R9) |
| opa_i | input | 8 | Operand A (destination register value) |
| opb_i | input | 8 | Operand B (source register or immediate) |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag, for chained subtract and compare |
| result_o | output | 8 | Operation result |
| flags_o | output | 6 | New flag values, layout in R1 |
| flags_we_o | output | 6 | Flags updated by this op, layout in R1 |
| res_wr_o | output | 1 | Result should be written back |

## Verification
The embedded checks assume that every input carries a known 0 or 1 value whenever they evaluate. Each check is guarded so that it stays silent while any operand, the op code or an incoming flag is unknown. The bench holds all inputs at defined values from time zero. It changes them only on falling clock edges and reads the outputs one nanosecond later, once the combinational paths have settled.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OPW   = 5;
  localparam int NFLAG = 6;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBC = 5'd3,
    OP_CP  = 5'd4,
    OP_CPC = 5'd5,
    OP_NEG = 5'd6,
    OP_COM = 5'd7,
    OP_AND = 5'd8,
    OP_OR  = 5'd9,
    OP_XOR = 5'd10,
    OP_SBR = 5'd11,
    OP_CBR = 5'd12,
    OP_INC = 5'd13,
    OP_DEC = 5'd14,
    OP_LSL = 5'd15,
    OP_LSR = 5'd16,
    OP_ROL = 5'd17
  } op_e;

  typedef enum logic [1:0] {
    BW_AND  = 2'd0,
    BW_OR   = 2'd1,
    BW_XOR  = 2'd2,
    BW_ANDN = 2'd3
  } bw_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ROL = 2'd2,
    SH_NOP = 2'd3
  } sh_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  input  logic         cin_i,   // carry for add, borrow for subtract
  output logic [W-1:0] r_o,
  output logic         c_o,     // carry out or borrow out of the top bit
  output logic         h_o,     // carry or borrow out of the low half
  output logic         v_o
);
  localparam int LW = W / 2;
  localparam int HW = W - LW;

  logic [W-1:0]  y_eff;
  logic          ci_eff;
  logic [LW:0]   lo_sum;
  logic [HW:0]   hi_sum;

  always_comb begin
    y_eff  = sub_i ? ~y_i : y_i;
    ci_eff = sub_i ? ~cin_i : cin_i;
    lo_sum = {1'b0, x_i[LW-1:0]} + {1'b0, y_eff[LW-1:0]} + {{LW{1'b0}}, ci_eff};
    hi_sum = {1'b0, x_i[W-1:LW]} + {1'b0, y_eff[W-1:LW]} + {{HW{1'b0}}, lo_sum[LW]};
    r_o    = {hi_sum[HW-1:0], lo_sum[LW-1:0]};
    c_o    = sub_i ? ~hi_sum[HW] : hi_sum[HW];
    h_o    = sub_i ? ~lo_sum[LW] : lo_sum[LW];
    v_o    = (x_i[W-1] == y_eff[W-1]) && (r_o[W-1] != x_i[W-1]);
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  bw_e          sel_i,
  output logic [W-1:0] r_o
);
  always_comb begin
    unique case (sel_i)
      BW_AND:  r_o = x_i & y_i;
      BW_OR:   r_o = x_i | y_i;
      BW_XOR:  r_o = x_i ^ y_i;
      default: r_o = x_i & ~y_i;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic         cin_i,
  input  sh_e          sel_i,
  output logic [W-1:0] r_o,
  output logic         c_o
);
  always_comb begin
    unique case (sel_i)
      SH_LSL: begin r_o = {x_i[W-2:0], 1'b0};  c_o = x_i[W-1]; end
      SH_LSR: begin r_o = {1'b0, x_i[W-1:1]};  c_o = x_i[0];   end
      SH_ROL: begin r_o = {x_i[W-2:0], cin_i}; c_o = x_i[W-1]; end
      default: begin r_o = x_i;                c_o = 1'b0;     end
    endcase
  end
endmodule

// File: rtl/alu8.sv
module alu8
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OPW-1:0]   op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             carry_i,
  input  logic             zero_i,
  output logic [WIDTH-1:0] result_o,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] flags_we_o,
  output logic             res_wr_o
);
  localparam logic [WIDTH-1:0] ONE    = WIDTH'(1);
  localparam logic [WIDTH-1:0] MAXPOS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MINNEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [NFLAG-1:0] M_ALL  = '1;
  localparam logic [NFLAG-1:0] M_NOH  = M_ALL & ~(NFLAG'(1) << FL_H);
  localparam logic [NFLAG-1:0] M_ZNVS = (NFLAG'(1) << FL_Z) | (NFLAG'(1) << FL_N) |
                                        (NFLAG'(1) << FL_V) | (NFLAG'(1) << FL_S);

  op_e op;
  assign op = op_e'(op_i);

  // adder operand steering
  logic [WIDTH-1:0] as_x, as_y, as_r;
  logic             as_sub, as_cin, as_c, as_h, as_v;

  always_comb begin
    as_x   = opa_i;
    as_y   = opb_i;
    as_sub = 1'b0;
    as_cin = 1'b0;
    unique case (op)
      OP_ADC:                as_cin = carry_i;
      OP_SUB, OP_CP:         as_sub = 1'b1;
      OP_SBC, OP_CPC: begin  as_sub = 1'b1; as_cin = carry_i; end
      OP_NEG: begin          as_x = '0; as_y = opa_i; as_sub = 1'b1; end
      OP_INC:                as_y = ONE;
      OP_DEC: begin          as_y = ONE; as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(WIDTH)) u_addsub (
    .x_i(as_x), .y_i(as_y), .sub_i(as_sub), .cin_i(as_cin),
    .r_o(as_r), .c_o(as_c), .h_o(as_h), .v_o(as_v)
  );

  // bitwise unit
  bw_e              bw_sel;
  logic [WIDTH-1:0] bw_r;

  always_comb begin
    unique case (op)
      OP_OR, OP_SBR: bw_sel = BW_OR;
      OP_XOR:        bw_sel = BW_XOR;
      OP_CBR:        bw_sel = BW_ANDN;
      default:       bw_sel = BW_AND;
    endcase
  end

  alu8_bitops #(.W(WIDTH)) u_bitops (
    .x_i(opa_i), .y_i(opb_i), .sel_i(bw_sel), .r_o(bw_r)
  );

  // shifter
  sh_e              sh_sel;
  logic [WIDTH-1:0] sh_r;
  logic             sh_c;

  always_comb begin
    unique case (op)
      OP_LSL:  sh_sel = SH_LSL;
      OP_LSR:  sh_sel = SH_LSR;
      OP_ROL:  sh_sel = SH_ROL;
      default: sh_sel = SH_NOP;
    endcase
  end

  alu8_shift #(.W(WIDTH)) u_shift (
    .x_i(opa_i), .cin_i(carry_i), .sel_i(sh_sel), .r_o(sh_r), .c_o(sh_c)
  );

  // result and flag assembly
  logic [WIDTH-1:0] res;
  logic             f_c, f_v, f_h, f_n, f_z, z_chain;
  logic [NFLAG-1:0] mask, fl;

  always_comb begin
    res      = '0;
    f_c      = 1'b0;
    f_v      = 1'b0;
    f_h      = 1'b0;
    z_chain  = 1'b0;
    mask     = '0;
    res_wr_o = 1'b1;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        res  = as_r;  f_c = as_c;  f_v = as_v;  f_h = as_h;
        mask = M_ALL;
        z_chain  = (op == OP_SBC) || (op == OP_CPC);
        res_wr_o = !((op == OP_CP) || (op == OP_CPC));
      end
      OP_COM: begin
        res = ~opa_i;  f_c = 1'b1;  mask = M_NOH;
      end
      OP_AND, OP_OR, OP_XOR, OP_SBR, OP_CBR: begin
        res = bw_r;  mask = M_ZNVS;
      end
      OP_INC, OP_DEC: begin
        res = as_r;  f_v = as_v;  mask = M_ZNVS;
      end
      OP_LSL, OP_LSR, OP_ROL: begin
        res = sh_r;  f_c = sh_c;  f_v = sh_r[WIDTH-1] ^ sh_c;  mask = M_NOH;
      end
      default: res_wr_o = 1'b0;
    endcase

    f_n = res[WIDTH-1];
    f_z = (res == '0) && (!z_chain || zero_i);

    fl       = '0;
    fl[FL_C] = f_c;
    fl[FL_Z] = f_z;
    fl[FL_N] = f_n;
    fl[FL_V] = f_v;
    fl[FL_S] = f_n ^ f_v;
    fl[FL_H] = f_h;

    result_o   = res;
    flags_we_o = mask;
    flags_o    = fl & mask;
  end

  // embedded checks, active only on fully known inputs
  always_comb begin
    if (!$isunknown({op_i, opa_i, opb_i, carry_i, zero_i})) begin
      // R7: overflow on increment only from the largest positive value
      a_r7_inc_ovf: assert (!(op == OP_INC && flags_o[FL_V]) || opa_i == MAXPOS)
        else $error("R7 INC overflow with operand %h", opa_i);
      // R7: overflow on decrement only from the most negative value
      a_r7_dec_ovf: assert (!(op == OP_DEC && flags_o[FL_V]) || opa_i == MINNEG)
        else $error("R7 DEC overflow with operand %h", opa_i);
      // R4: chained ops can only keep or clear Z
      a_r4_chain_zero: assert (!((op == OP_SBC || op == OP_CPC) && flags_o[FL_Z]) || zero_i)
        else $error("R4 chained Z set without incoming Z");
      // R8: shifted-out bit lands in carry
      a_r8_shift_carry: assert (!(op == OP_LSR) || flags_o[FL_C] == opa_i[0])
        else $error("R8 LSR carry mismatch");
      // R6: logic ops leave C and H unwritten
      a_r6_keep_ch: assert (!(op inside {OP_AND, OP_OR, OP_XOR, OP_SBR, OP_CBR, OP_INC, OP_DEC})
                            || (!flags_we_o[FL_C] && !flags_we_o[FL_H]))
        else $error("R6 C/H written by logic op");
      // R9: unused codes are idle
      a_r9_idle: assert (op_i <= OPW'(17) || (flags_we_o == '0 && !res_wr_o && result_o == '0))
        else $error("R9 unused op not idle");
      // R1: unwritten flags read zero
      a_r1_unwritten_zero: assert ((flags_o & ~flags_we_o) == '0)
        else $error("R1 unwritten flag nonzero");
    end
  end

endmodule

// File: tb/alu8_bench.sv
`timescale 1ns/1ps
module alu8_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic       cin = 1'b0, zin = 1'b0;
  logic [7:0] res;
  logic [5:0] fl, we;
  logic       wr;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  alu8 u_alu8 (
    .op_i(op), .opa_i(a), .opb_i(b), .carry_i(cin), .zero_i(zin),
    .result_o(res), .flags_o(fl), .flags_we_o(we), .res_wr_o(wr)
  );

  // Expected outputs from the requirements: {wr, we, fl, res}
  function automatic logic [20:0] model(input logic [4:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic c, input logic z);
    int r, sx, sy, ci, lo;
    logic [7:0] rr;
    logic fc, fv, fh, fz, fn, w;
    logic [5:0] m, f;
    fc = 0; fv = 0; fh = 0; w = 1; m = 6'h00;
    sx = int'($signed(x)); sy = int'($signed(y));
    rr = 8'h00;
    if (o <= 5'd1) begin
      ci = (o == 5'd1) ? int'(c) : 0;
      r  = int'(x) + int'(y) + ci;
      rr = 8'(r); fc = (r > 255);
      fh = (int'(x[3:0]) + int'(y[3:0]) + ci) > 15;
      fv = (sx + sy + ci > 127) || (sx + sy + ci < -128);
      m  = 6'h3F;
    end else if (o <= 5'd5) begin
      ci = (o == 5'd3 || o == 5'd5) ? int'(c) : 0;
      r  = int'(x) - int'(y) - ci;
      rr = 8'(r); fc = (r < 0);
      fh = (int'(x[3:0]) - int'(y[3:0]) - ci) < 0;
      fv = (sx - sy - ci > 127) || (sx - sy - ci < -128);
      m  = 6'h3F; w = (o <= 5'd3);
    end else if (o == 5'd6) begin
      rr = 8'(0 - int'(x)); fc = (x != 0); fh = (x[3:0] != 0); fv = (x == 8'h80); m = 6'h3F;
    end else if (o == 5'd7) begin
      rr = 8'hFF - x; fc = 1; m = 6'h1F;
    end else if (o <= 5'd12) begin
      case (o)
        5'd8:  rr = x & y;
        5'd9:  rr = x | y;
        5'd10: rr = x ^ y;
        5'd11: rr = x | y;
        default: rr = x & (8'hFF - y);
      endcase
      m = 6'h1E;
    end else if (o == 5'd13) begin
      rr = 8'(int'(x) + 1); fv = (x == 8'h7F); m = 6'h1E;
    end else if (o == 5'd14) begin
      rr = 8'(int'(x) - 1); fv = (x == 8'h80); m = 6'h1E;
    end else if (o <= 5'd17) begin
      if (o == 5'd16) begin rr = x / 2; fc = x[0]; end
      else begin rr = 8'((int'(x) * 2) + ((o == 5'd17) ? int'(c) : 0)); fc = x[7]; end
      fv = rr[7] ^ fc; m = 6'h1F;
    end else begin
      w = 0;
    end
    fn = rr[7];
    fz = (rr == 8'h00) && (!(o == 5'd3 || o == 5'd5) || z);
    f  = {fh, fn ^ fv, fv, fn, fz, fc} & m;
    return {w, m, f, rr};
  endfunction

  task automatic chk(input string tag, input logic [4:0] o, input logic [7:0] x,
                     input logic [7:0] y, input logic c, input logic z);
    logic [20:0] exp_v, act;
    @(negedge clk);
    op = o; a = x; b = y; cin = c; zin = z;
    #1;
    exp_v = model(o, x, y, c, z);
    act   = {wr, we, fl, res};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h c=%b z=%b actual wr=%b we=%h fl=%h res=%h expected wr=%b we=%h fl=%h res=%h",
               tag, o, x, y, c, z, act[20], act[19:14], act[13:8], act[7:0],
               exp_v[20], exp_v[19:14], exp_v[13:8], exp_v[7:0]);
    end
  endtask

  task automatic t_reset();  // R1, R10
    chk("R1 idle after reset", 5'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    chk("R10 same-cycle response", 5'd0, 8'h12, 8'h34, 1'b0, 1'b0);
  endtask

  task automatic t_add();  // R2
    chk("R2 add half carry", 5'd0, 8'h0F, 8'h01, 1'b0, 1'b0);
    chk("R2 add overflow",   5'd0, 8'h7F, 8'h01, 1'b0, 1'b0);
    chk("R2 add wrap zero",  5'd0, 8'hFF, 8'h01, 1'b0, 1'b0);
    chk("R2 add neg ovf",    5'd0, 8'h80, 8'h80, 1'b0, 1'b0);
    chk("R2 adc carry in",   5'd1, 8'hFE, 8'h01, 1'b1, 1'b0);
    chk("R2 adc no cin",     5'd1, 8'h10, 8'h20, 1'b0, 1'b0);
  endtask

  task automatic t_sub();  // R3
    chk("R3 sub half borrow", 5'd2, 8'h10, 8'h01, 1'b0, 1'b0);
    chk("R3 sub borrow",      5'd2, 8'h00, 8'h01, 1'b0, 1'b0);
    chk("R3 sub overflow",    5'd2, 8'h80, 8'h01, 1'b0, 1'b0);
    chk("R3 sbc with borrow", 5'd3, 8'h05, 8'h05, 1'b1, 1'b1);
  endtask

  task automatic t_chain();  // R4
    chk("R4 sbc zero kept",   5'd3, 8'h42, 8'h42, 1'b0, 1'b1);
    chk("R4 sbc zero held 0", 5'd3, 8'h42, 8'h42, 1'b0, 1'b0);
    chk("R4 cpc zero kept",   5'd5, 8'h43, 8'h42, 1'b1, 1'b1);
    chk("R4 cpc zero held 0", 5'd5, 8'h43, 8'h42, 1'b1, 1'b0);
    chk("R4 cpc nonzero",     5'd5, 8'h50, 8'h42, 1'b0, 1'b1);
    chk("R4 cp no write",     5'd4, 8'h33, 8'h33, 1'b1, 1'b0);
  endtask

  task automatic t_negcom();  // R5
    chk("R5 neg zero",  5'd6, 8'h00, 8'h00, 1'b0, 1'b0);
    chk("R5 neg min",   5'd6, 8'h80, 8'h00, 1'b0, 1'b0);
    chk("R5 neg one",   5'd6, 8'h01, 8'h00, 1'b0, 1'b0);
    chk("R5 com ones",  5'd7, 8'hFF, 8'h00, 1'b0, 1'b0);
    chk("R5 com value", 5'd7, 8'h5A, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_logic();  // R6
    chk("R6 and zero", 5'd8,  8'hF0, 8'h0F, 1'b1, 1'b0);
    chk("R6 or neg",   5'd9,  8'h80, 8'h01, 1'b1, 1'b0);
    chk("R6 xor self", 5'd10, 8'hA5, 8'hA5, 1'b0, 1'b0);
    chk("R6 set bits", 5'd11, 8'h01, 8'h90, 1'b0, 1'b0);
    chk("R6 clr bits", 5'd12, 8'hFF, 8'h81, 1'b1, 1'b0);
  endtask

  task automatic t_incdec();  // R7
    chk("R7 inc 7F", 5'd13, 8'h7F, 8'h00, 1'b1, 1'b0);
    chk("R7 inc FF", 5'd13, 8'hFF, 8'h00, 1'b0, 1'b0);
    chk("R7 dec 80", 5'd14, 8'h80, 8'h00, 1'b0, 1'b0);
    chk("R7 dec 00", 5'd14, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R7 dec 01", 5'd14, 8'h01, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_shift();  // R8
    chk("R8 lsl top", 5'd15, 8'h81, 8'h00, 1'b1, 1'b0);
    chk("R8 lsl neg", 5'd15, 8'h40, 8'h00, 1'b0, 1'b0);
    chk("R8 lsr low", 5'd16, 8'h01, 8'h00, 1'b1, 1'b0);
    chk("R8 lsr mid", 5'd16, 8'hF2, 8'h00, 1'b0, 1'b0);
    chk("R8 rol cin", 5'd17, 8'h80, 8'h00, 1'b1, 1'b0);
    chk("R8 rol no cin", 5'd17, 8'h55, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_unused();  // R9
    chk("R9 op 18", 5'd18, 8'hFF, 8'hFF, 1'b1, 1'b1);
    chk("R9 op 31", 5'd31, 8'h12, 8'h34, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_chain();
    t_negcom();
    t_logic();
    t_incdec();
    t_shift();
    t_unused();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule